// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit with Flag-Driven Byte Pick

This block is a datapath slice that splits two 32-bit operands into independent lanes and adds or subtracts them lane by lane. There are two lane sizes: two 16-bit halves or four 8-bit bytes. Each lane is truncated to its own width, so no carry passes from one lane into the next. For each lane the unit also records whether the lane carried (on an add) or did not borrow (on a subtract). These results are kept in a persistent 4-bit lane-flag register, one bit per byte position.

A fifth operation, the byte pick, builds a result from both operands. For each byte it takes the byte from operand A when the matching lane flag is set, and the byte from operand B when it is clear. A typical use is to compare two packed vectors with a subtract and then use the pick to build a per-lane maximum or minimum. The operation is presented for one cycle with `in_valid`. Its result, the flag register and a flag write strobe are visible on the following cycle.

Top module: `simd_addsub`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the unit clears `out_valid`, `flag_we`, `result` and `flags` to zero.
- R2: An operation accepted with `in_valid` high at a rising edge shows `out_valid` high and its `result` after that edge. `out_valid` is low in the cycle after any edge at which `in_valid` was low.
- R3: The opcodes are 000 halfword add, 001 halfword subtract, 010 byte add, 011 byte subtract and 100 byte pick. Lane 0 occupies `result[15:0]` for halfwords or `result[7:0]` for bytes. Each lane result is taken modulo its own width, so no carry or borrow enters the neighbouring lane.
- R4: Halfword add: `flags[1:0]` becomes 11 when the low half carries out and 00 otherwise, and `flags[3:2]` does the same for the high half.
- R5: Halfword subtract: each half of the result is A minus B modulo 2^16. The flag pair of that half becomes 11 when A's half is greater than or equal to B's half, and 00 when it is less.
- R6: Byte add: each byte of the result is the lane sum modulo 256, and `flags[i]` becomes 1 exactly when byte lane i carries out.
- R7: Byte subtract: each byte of the result is the lane difference modulo 256, and `flags[i]` becomes 1 exactly when byte i of A is greater than or equal to byte i of B.
- R8: Every add or subtract rewrites all four flag bits, so a bit set by an earlier operation is cleared when the new condition is false.
- R9: Byte pick: `result` byte i equals byte i of A when `flags[i]` is 1 and byte i of B when it is 0. It uses the flag value committed before the edge that accepts the pick, which includes a flag update by an operation on the immediately preceding cycle.
- R10: A byte pick leaves `flags` unchanged and keeps `flag_we` low.
- R11: Opcodes 101, 110 and 111 produce a zero `result`, keep `flag_we` low and leave `flags` unchanged.
- R12: `flag_we` is high exactly in the cycle after an accepted add or subtract, and in that cycle `flags` already shows the new value. Cycles without an accepted operation leave `flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| op | input | 3 | Operation code (see R3) |
| opnd_a | input | 32 | First packed operand |
| opnd_b | input | 32 | Second packed operand |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| result | output | 32 | Packed lane result |
| flags | output | 4 | Lane-flag register, bit i for byte position i |
| flag_we | output | 1 | High in the cycle after the flag register was written |

## Verification
The bench drives all-ones plus one and equal-operand subtracts, where every lane sits exactly on its carry or borrow boundary. A design that let a carry cross lanes would corrupt the neighbouring lane, and one that tested greater-than instead of greater-or-equal would clear the flag on equal inputs. Flags are set by one operation and must then be cleared by a following one; a unit that only ever set bits would show stale ones. A pick issued immediately after a flag-changing subtract would use an out-of-date mask if the flag path lagged by a cycle. Undefined opcodes and picks are interleaved with arithmetic operations, so a design that writes flags on them would drift away from the reference model that is compared on every clock.

// File: rtl/simd_pkg.sv
// Package: shared widths and operation codes for the packed add/subtract unit.
// Assumes the data width is a multiple of twice the byte width.
package simd_pkg;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int NBYTE  = DATA_W / BYTE_W;

    typedef enum logic [2:0] {
        OP_ADD_H = 3'b000,
        OP_SUB_H = 3'b001,
        OP_ADD_B = 3'b010,
        OP_SUB_B = 3'b011,
        OP_PICK  = 3'b100
    } simd_op_e;
endpackage

// File: rtl/simd_lane_alu.sv
// Module: lane-parallel adder/subtractor.
// Splits the operands into DATA_W/LANE_W independent lanes. Subtraction is
// formed as a + ~b + 1, so a lane's carry out means "no borrow".
// Assumes DATA_W is a multiple of LANE_W. Purely combinational.
module simd_lane_alu #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int NLANE = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic [NLANE-1:0]  cout
);
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [LANE_W-1:0] a_l, b_l;
        logic [LANE_W:0]   t;
        // One lane: widened add with optional inversion and carry-in.
        always_comb begin
            a_l = a[l*LANE_W +: LANE_W];
            b_l = sub ? ~b[l*LANE_W +: LANE_W] : b[l*LANE_W +: LANE_W];
            t   = {1'b0, a_l} + {1'b0, b_l} + {{LANE_W{1'b0}}, sub};
        end
        assign sum[l*LANE_W +: LANE_W] = t[LANE_W-1:0];
        assign cout[l]                 = t[LANE_W];
    end
endmodule

// File: rtl/simd_byte_pick.sv
// Module: byte-wise merge of two operands under a per-byte mask.
// Byte i comes from a when sel[i] is set, else from b. Combinational.
module simd_byte_pick #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTE = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [NBYTE-1:0]  sel,
    output logic [DATA_W-1:0] y
);
    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        assign y[i*BYTE_W +: BYTE_W] = sel[i] ? a[i*BYTE_W +: BYTE_W]
                                              : b[i*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/simd_addsub.sv
// Module: top of the packed add/subtract unit.
// Registers the selected lane result, a persistent lane-flag register and a
// flag write strobe. Picks read the flag register before the accepting edge.
// Assumes one operation per in_valid cycle; synchronous active-low reset.
module simd_addsub
    import simd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BW = BYTE_W,
    localparam int NB = DW / BW,
    localparam int NH = NB / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    op,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic [NB-1:0] flags,
    output logic          flag_we
);
    logic [DW-1:0] sum_h, sum_b, pick_y, next_res;
    logic [NH-1:0] cout_h;
    logic [NB-1:0] cout_b, flag_h, next_flags;
    logic          is_arith;
    logic [2:0]    op_q;

    simd_lane_alu #(.DATA_W(DW), .LANE_W(2*BW)) u_half (
        .a(opnd_a), .b(opnd_b), .sub(op[0]), .sum(sum_h), .cout(cout_h)
    );

    simd_lane_alu #(.DATA_W(DW), .LANE_W(BW)) u_byte (
        .a(opnd_a), .b(opnd_b), .sub(op[0]), .sum(sum_b), .cout(cout_b)
    );

    simd_byte_pick #(.DATA_W(DW), .BYTE_W(BW)) u_pick (
        .a(opnd_a), .b(opnd_b), .sel(flags), .y(pick_y)
    );

    // Each halfword carry drives both flag bits of its byte pair.
    for (genvar j = 0; j < NB; j++) begin : g_hflag
        assign flag_h[j] = cout_h[j/2];
    end

    // Select result and candidate flags from the opcode.
    always_comb begin
        is_arith   = 1'b0;
        next_res   = '0;
        next_flags = flags;
        case (op)
            OP_ADD_H, OP_SUB_H: begin
                is_arith   = 1'b1;
                next_res   = sum_h;
                next_flags = flag_h;
            end
            OP_ADD_B, OP_SUB_B: begin
                is_arith   = 1'b1;
                next_res   = sum_b;
                next_flags = cout_b;
            end
            OP_PICK: next_res = pick_y;
            default: next_res = '0;
        endcase
    end

    // Output, strobe and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            flag_we   <= 1'b0;
            result    <= '0;
            flags     <= '0;
            op_q      <= 3'b000;
        end else begin
            out_valid <= in_valid;
            flag_we   <= in_valid && is_arith;
            if (in_valid) begin
                result <= next_res;
                op_q   <= op;
            end
            if (in_valid && is_arith) flags <= next_flags;
        end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !op[2]) |=> $stable(flags)); // R10

    AST_WE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> out_valid); // R12

    AST_PICK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2]) |=> !flag_we); // R11

    AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q[2] && (op_q[1:0] != 2'b00)) |-> (result == '0)); // R11

    for (genvar h = 0; h < NH; h++) begin : g_pair_chk
        AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_we && !op_q[1]) |-> (flags[2*h] == flags[2*h+1])); // R4
    end
endmodule

// File: tb/sim_simd_addsub.sv
module sim_simd_addsub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        out_valid, flag_we;
    logic [31:0] result;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;

    logic        e_valid = 1'b0, e_we = 1'b0;
    logic [31:0] e_res = '0;
    logic [3:0]  e_flags = '0;

    always #5 clk = ~clk;

    simd_addsub u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .result(result), .flags(flags), .flag_we(flag_we)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: advances model state for one accepted edge.
    task automatic model(input logic v, input logic [2:0] o,
                         input logic [31:0] a, input logic [31:0] b);
        int x, y, s, w, n;
        logic [31:0] r;
        logic [3:0]  f;
        e_valid = v;
        e_we = 1'b0;
        if (!v) return;
        r = '0;
        f = e_flags;
        if (o <= 3) begin
            w = (o <= 1) ? 16 : 8;
            n = 32 / w;
            for (int i = 0; i < n; i++) begin
                x = int'((a >> (w*i)) & ((32'd1 << w) - 1));
                y = int'((b >> (w*i)) & ((32'd1 << w) - 1));
                if (o[0] == 1'b0) begin
                    s = x + y;
                    for (int k = 0; k < w/8; k++) f[i*(w/8)+k] = (s >= (1 << w));
                end else begin
                    s = x - y + (1 << w);
                    for (int k = 0; k < w/8; k++) f[i*(w/8)+k] = (x >= y);
                end
                r = r | ((32'(s) & ((32'd1 << w) - 1)) << (w*i));
            end
            e_we = 1'b1;
        end else if (o == 3'd4) begin
            for (int i = 0; i < 4; i++)
                r[8*i +: 8] = e_flags[i] ? a[8*i +: 8] : b[8*i +: 8];
        end
        e_res = r;
        e_flags = f;
    endtask

    task automatic step(input logic v, input logic [2:0] o,
                        input logic [31:0] a, input logic [31:0] b,
                        input string tag);
        in_valid = v; op = o; opnd_a = a; opnd_b = b;
        @(posedge clk);
        model(v, o, a, b);
        @(negedge clk);
        check("R2", "out_valid", 32'(out_valid), 32'(e_valid));
        check("R12", "flag_we", 32'(flag_we), 32'(e_we));
        check(tag, "flags", 32'(flags), 32'(e_flags));
        if (e_valid) check(tag, "result", result, e_res);
    endtask

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R9";
            default: return "R11";
        endcase
    endfunction

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "out_valid", 32'(out_valid), 32'd0);
        check("R1", "flag_we", 32'(flag_we), 32'd0);
        check("R1", "result", result, 32'd0);
        check("R1", "flags", 32'(flags), 32'd0);
        rst_n = 1'b1;
        step(1'b0, 3'd0, 32'h0, 32'h0, "R12");
        step(1'b1, 3'd0, 32'h0001_FFFF, 32'h0000_0001, "R3");
        step(1'b1, 3'd0, 32'hFFFF_0001, 32'h0001_0001, "R4");
        step(1'b1, 3'd1, 32'h1234_0005, 32'h1234_0006, "R5");
        step(1'b1, 3'd2, 32'hFF01_80FF, 32'h01FF_8001, "R6");
        step(1'b1, 3'd3, 32'h0010_2005, 32'h0110_2105, "R7");
        step(1'b1, 3'd3, 32'hFFFF_FFFF, 32'h0000_0000, "R8");
        step(1'b1, 3'd2, 32'h0101_0101, 32'h0101_0101, "R8");
        step(1'b1, 3'd3, 32'h80FF_0180, 32'h7F00_0280, "R9");
        step(1'b1, 3'd4, 32'hAABB_CCDD, 32'h1122_3344, "R9");
        step(1'b1, 3'd4, 32'h5566_7788, 32'h99AA_BBCC, "R10");
        step(1'b0, 3'd1, 32'hFFFF_FFFF, 32'h0, "R12");
        step(1'b1, 3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11");
        step(1'b1, 3'd7, 32'h1234_5678, 32'h8765_4321, "R11");
        step(1'b1, 3'd1, 32'h0000_0000, 32'h0000_0000, "R5");
        step(1'b1, 3'd4, 32'hDEAD_BEEF, 32'h0, "R9");
        for (int n = 0; n < 600; n++) begin
            logic [2:0] o;
            o = 3'($urandom_range(0, 7));
            step(($urandom_range(0, 3) != 0), o, $urandom, $urandom, tag_of(o));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule